// File: doc/BRIEF.md
# Serial Management Bus Responder

This block is the device-side responder for a two-wire serial management bus made up of a clock line and one bidirectional data line. Every data-line sample and every value the block drives is timed by the rising edge of the management clock. The block watches the line for a run of ones that announces a frame. It then decodes the start pattern, the operation code, a device address and a register address. If the device address matches the value on `phy_addr_cfg`, the block either stores the 16-bit data word the station sends into a small register file, or returns a register's contents. On a return, the block drives the data line through a separate output enable.

The frame decoder is a single enumerated state machine.
- `ST_IDLE` counts consecutive ones. It goes to `ST_SFD` on a zero, provided the ones run was long enough or the shortened-preamble rule allows it.
- `ST_SFD` goes to `ST_OPC` on a one and returns to `ST_IDLE` on a zero.
- `ST_OPC` collects two bits. It continues to `ST_PHYA` on a read or write code and drops back to `ST_IDLE` on any other code.
- `ST_PHYA` and `ST_REGA` each take five bits. `ST_REGA` goes to `ST_TURN` when the address matched and to `ST_SKIP` when it did not.
- `ST_TURN` spends two bits, then enters `ST_RDATA` or `ST_WDATA`.
- `ST_RDATA`, `ST_WDATA` and `ST_SKIP` return to `ST_IDLE` at the end of the data field.

The register file holds the following registers:
- A control register. One of its bits enables shortened preambles.
- A read-only status register, which advertises that shortened preambles are supported.
- A bank of scratch registers.

Top module: `mdio_slave`

## Requirements
- R1: After reset, `mdio_oe` is low, the control register and all scratch registers read 0x0000.
- R2: A frame is recognised only when at least 32 consecutive ones precede the start pattern 0 then 1. A frame with fewer ones causes no drive of the line and no register write.
- R3: The opcode is two bits. 10 is a read and 01 is a write. Codes 00 and 11 abandon the frame, with no drive and no write, and the block returns to waiting for a preamble.
- R4: The 5-bit device address, sent MSB first, is compared with `phy_addr_cfg`. On a mismatch the block never raises `mdio_oe`, and a write does not change any register.
- R5: On a matching read, `mdio_oe` stays low during the first turnaround bit. It is high with `mdio_o` = 0 during the second turnaround bit. It stays high for the 16 data bits, which are sent MSB first, and is low again in the bit period after the last data bit.
- R6: On a matching write, the station drives turnaround 1 then 0, and the 16 data bits, MSB first, are stored into the register given by the 5-bit register address, also sent MSB first.
- R7: Register address 0 is a 16-bit read/write control register. Address 1 is a read-only status register that reads 0x0040, where bit 6 set means shortened preambles are accepted, and writes to it are ignored. Addresses 16 to 19 are 16-bit read/write scratch registers.
- R8: Any other register address reads back 0x0000, and writes to it are discarded.
- R9: While control bit 6 is set and at least one frame has completed since reset, a single one followed by the start pattern is enough to begin a frame. With bit 6 clear, the 32-one rule of R2 applies again.
- R10: Both `mdio_oe` and `mdio_o` are registered on the rising edge of `mdc`. Each value they take is the one sampled by the station on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling and launching on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Resolved level of the data line |
| phy_addr_cfg | input | 5 | Device address this responder answers to |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line driver |

## Verification
The bench builds the block with its default parameters: a 5-bit address, a 16-bit data field, a 32-one preamble, four scratch registers starting at address 16, and the shortened-preamble capability present. A 31-one preamble therefore sits exactly one bit short of the threshold. The bench also switches the shortened-preamble bit on and off to reach both sides of R9. With four scratch registers, addresses 19 and 20 bracket the end of the implemented space. Changing `phy_addr_cfg` to the all-ones address, and sending frames to a neighbouring address, exercises both outcomes of the address compare.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SFD,
        ST_OPC,
        ST_PHYA,
        ST_REGA,
        ST_TURN,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } mdio_st_e;

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;

endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
    parameter int AW       = 5,
    parameter int DW       = 16,
    parameter int NSCR     = 4,
    parameter int SCR_BASE = 16,
    parameter bit SUPP_CAP = 1'b1,
    parameter int SUPP_BIT = 6
) (
    input  logic          mdc,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          supp_en
);

    localparam logic [AW-1:0] ADR_CTRL = AW'(0);
    localparam logic [AW-1:0] ADR_STAT = AW'(1);
    localparam logic [DW-1:0] STAT_VAL = SUPP_CAP ? (DW'(1) << SUPP_BIT) : '0;

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] scr_q [NSCR];

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && addr == ADR_CTRL) begin
            ctrl_q <= wr_data;
        end
    end

    for (genvar g = 0; g < NSCR; g++) begin : g_scr
        localparam logic [AW-1:0] SA = AW'(SCR_BASE + g);
        always_ff @(posedge mdc or negedge rst_n) begin
            if (!rst_n) begin
                scr_q[g] <= '0;
            end else if (wr_en && addr == SA) begin
                scr_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADR_CTRL) begin
            rd_data = ctrl_q;
        end else if (addr == ADR_STAT) begin
            rd_data = STAT_VAL;
        end
        for (int i = 0; i < NSCR; i++) begin
            if (addr == AW'(SCR_BASE + i)) begin
                rd_data = scr_q[i];
            end
        end
    end

    assign supp_en = SUPP_CAP & ctrl_q[SUPP_BIT];

    // R7: control register changes only through a write aimed at it
    p_ctrl_hold_r7: assert property (@(posedge mdc) disable iff (!rst_n)
        !(wr_en && addr == ADR_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slave_pkg::*;
#(
    parameter int AW      = 5,
    parameter int DW      = 16,
    parameter int PRE_LEN = 32
) (
    input  logic          mdc,
    input  logic          rst_n,
    input  logic          mdio_i,
    input  logic [AW-1:0] phy_addr_cfg,
    input  logic          supp_en,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] reg_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          mdio_o,
    output logic          mdio_oe
);

    localparam int CW  = $clog2(PRE_LEN + 1);
    localparam int BCW = $clog2(DW + 2);
    localparam logic [CW-1:0]  PRE_FULL  = CW'(PRE_LEN);
    localparam logic [BCW-1:0] AD_LAST   = BCW'(AW - 1);
    localparam logic [BCW-1:0] DAT_LAST  = BCW'(DW - 1);
    localparam logic [BCW-1:0] SKIP_LAST = BCW'(DW + 1);

    mdio_st_e       state, nxt;
    logic [CW-1:0]  pre_cnt;
    logic [BCW-1:0] bit_cnt;
    logic           had_frame;
    logic [1:0]     op_q;
    logic [AW-1:0]  phy_sh;
    logic [AW-1:0]  reg_sh;
    logic           phy_hit;
    logic [DW-1:0]  wsh;
    logic [DW:0]    tx;
    logic           pre_ok;
    logic           frame_done;

    assign pre_ok = (pre_cnt >= PRE_FULL) ||
                    (supp_en && had_frame && pre_cnt != '0);

    assign frame_done = ((state == ST_WDATA || state == ST_RDATA) && bit_cnt == DAT_LAST) ||
                        (state == ST_SKIP && bit_cnt == SKIP_LAST);

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!mdio_i && pre_ok) nxt = ST_SFD;
            ST_SFD:   nxt = mdio_i ? ST_OPC : ST_IDLE;
            ST_OPC:   if (bit_cnt[0]) nxt = (op_q[0] != mdio_i) ? ST_PHYA : ST_IDLE;
            ST_PHYA:  if (bit_cnt == AD_LAST) nxt = ST_REGA;
            ST_REGA:  if (bit_cnt == AD_LAST) nxt = phy_hit ? ST_TURN : ST_SKIP;
            ST_TURN:  if (bit_cnt[0]) nxt = (op_q == OPC_RD) ? ST_RDATA : ST_WDATA;
            ST_WDATA: if (bit_cnt == DAT_LAST) nxt = ST_IDLE;
            ST_RDATA: if (bit_cnt == DAT_LAST) nxt = ST_IDLE;
            ST_SKIP:  if (bit_cnt == SKIP_LAST) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // frame datapath
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt   <= '0;
            bit_cnt   <= '0;
            had_frame <= 1'b0;
            op_q      <= '0;
            phy_sh    <= '0;
            reg_sh    <= '0;
            phy_hit   <= 1'b0;
            wsh       <= '0;
        end else begin
            bit_cnt <= (nxt != state) ? '0 : bit_cnt + 1'b1;
            if (state == ST_IDLE && mdio_i) begin
                if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
            end else begin
                pre_cnt <= '0;
            end
            if (frame_done) had_frame <= 1'b1;
            if (state == ST_OPC) op_q <= {op_q[0], mdio_i};
            if (state == ST_PHYA) begin
                phy_sh <= {phy_sh[AW-2:0], mdio_i};
                if (bit_cnt == AD_LAST)
                    phy_hit <= ({phy_sh[AW-2:0], mdio_i} == phy_addr_cfg);
            end
            if (state == ST_REGA)  reg_sh <= {reg_sh[AW-2:0], mdio_i};
            if (state == ST_WDATA) wsh    <= {wsh[DW-2:0], mdio_i};
        end
    end

    assign reg_addr = reg_sh;
    assign wr_en    = (state == ST_WDATA) && (bit_cnt == DAT_LAST);
    assign wr_data  = {wsh[DW-2:0], mdio_i};

    // output process: line driver
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            mdio_oe <= 1'b0;
            tx      <= '0;
        end else if (state == ST_TURN && bit_cnt == '0 && op_q == OPC_RD) begin
            mdio_oe <= 1'b1;
            tx      <= {1'b0, rd_data};
        end else if (state == ST_RDATA && bit_cnt == DAT_LAST) begin
            mdio_oe <= 1'b0;
            tx      <= '0;
        end else if (mdio_oe) begin
            tx      <= {tx[DW-1:0], 1'b0};
        end
    end

    assign mdio_o = tx[DW];

    // R5: the line is free whenever the decoder is waiting for a frame
    p_idle_quiet_r5: assert property (@(posedge mdc) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mdio_oe);

    // R5: the responder's turnaround bit is a zero
    p_ta_low_r5: assert property (@(posedge mdc) disable iff (!rst_n)
        (mdio_oe && state == ST_TURN) |-> !mdio_o);

    // R5: release right after the last data bit
    p_release_r5: assert property (@(posedge mdc) disable iff (!rst_n)
        (state == ST_RDATA && bit_cnt == DAT_LAST) |=> !mdio_oe);

    // R4: a foreign frame never gets the driver
    p_skip_silent_r4: assert property (@(posedge mdc) disable iff (!rst_n)
        (state == ST_SKIP) |-> !mdio_oe);

    // R3: equal opcode bits abandon the frame
    p_bad_opc_r3: assert property (@(posedge mdc) disable iff (!rst_n)
        (state == ST_OPC && bit_cnt[0] && op_q[0] == mdio_i) |=> (state == ST_IDLE));

    // R6: a store only follows a matching address
    p_wr_hit_r6: assert property (@(posedge mdc) disable iff (!rst_n)
        wr_en |-> phy_hit);

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
    parameter int AW       = 5,
    parameter int DW       = 16,
    parameter int PRE_LEN  = 32,
    parameter int NSCR     = 4,
    parameter int SCR_BASE = 16,
    parameter bit SUPP_CAP = 1'b1,
    parameter int SUPP_BIT = 6
) (
    input  logic          mdc,
    input  logic          rst_n,
    input  logic          mdio_i,
    input  logic [AW-1:0] phy_addr_cfg,
    output logic          mdio_o,
    output logic          mdio_oe
);

    logic [AW-1:0] reg_addr;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          supp_en;

    mdio_frame_fsm #(
        .AW      (AW),
        .DW      (DW),
        .PRE_LEN (PRE_LEN)
    ) u_fsm (
        .mdc          (mdc),
        .rst_n        (rst_n),
        .mdio_i       (mdio_i),
        .phy_addr_cfg (phy_addr_cfg),
        .supp_en      (supp_en),
        .rd_data      (rd_data),
        .reg_addr     (reg_addr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe)
    );

    mdio_regfile #(
        .AW       (AW),
        .DW       (DW),
        .NSCR     (NSCR),
        .SCR_BASE (SCR_BASE),
        .SUPP_CAP (SUPP_CAP),
        .SUPP_BIT (SUPP_BIT)
    ) u_regs (
        .mdc     (mdc),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .supp_en (supp_en)
    );

endmodule

// File: tb/mdio_slave_tb.sv
module mdio_slave_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       drv;
    logic [4:0] cfg;
    wire        mdio_o;
    wire        mdio_oe;
    wire        line = mdio_oe ? mdio_o : drv;

    always #2 clk = ~clk;

    mdio_slave u_dut (
        .mdc          (clk),
        .rst_n        (rst_n),
        .mdio_i       (line),
        .phy_addr_cfg (cfg),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_reg [32];
    bit m_had;

    function automatic bit m_impl(int a);
        return (a == 0) || (a == 1) || (a >= 16 && a < 20);
    endfunction

    function automatic logic [15:0] m_read(int a);
        if (a == 1) return 16'h0040;
        if (!m_impl(a)) return 16'h0000;
        return m_reg[a];
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit b, bit rel, bit e_oe, bit e_o, string tag, output bit seen);
        @(negedge clk);
        chk(tag, {15'b0, mdio_oe}, {15'b0, e_oe});
        if (e_oe) chk(tag, {15'b0, mdio_o}, {15'b0, e_o});
        seen = mdio_o;
        drv  = rel ? 1'b1 : b;
    endtask

    task automatic frame(int pre, bit [1:0] op, bit [4:0] phy, bit [4:0] ra,
                         bit [15:0] wd, string tag);
        bit acc, valid, hit, rd, s;
        logic [15:0] exp, got;
        acc   = (pre >= 32) || (m_reg[0][6] && m_had && pre >= 1);
        valid = acc && (op == 2'b10 || op == 2'b01);
        hit   = valid && (phy == cfg);
        rd    = hit && (op == 2'b10);
        exp   = m_read(int'(ra));
        got   = '0;
        for (int i = 0; i < pre; i++) step(1'b1, 1'b0, 1'b0, 1'b0, tag, s);
        step(1'b0, 1'b0, 1'b0, 1'b0, tag, s);
        step(1'b1, 1'b0, 1'b0, 1'b0, tag, s);
        for (int i = 1; i >= 0; i--) step(op[i], 1'b0, 1'b0, 1'b0, tag, s);
        for (int i = 4; i >= 0; i--) step(phy[i], 1'b0, 1'b0, 1'b0, tag, s);
        for (int i = 4; i >= 0; i--) step(ra[i], 1'b0, 1'b0, 1'b0, tag, s);
        if (op == 2'b10) begin
            step(1'b1, 1'b1, 1'b0, 1'b0, tag, s);
            step(1'b1, 1'b1, rd, 1'b0, tag, s);
            for (int i = 15; i >= 0; i--) begin
                step(1'b1, 1'b1, rd, exp[i], tag, s);
                got[i] = s;
            end
            if (rd) chk(tag, got, exp);
        end else begin
            step(1'b1, 1'b0, 1'b0, 1'b0, tag, s);
            step(1'b0, 1'b0, 1'b0, 1'b0, tag, s);
            for (int i = 15; i >= 0; i--) step(wd[i], 1'b0, 1'b0, 1'b0, tag, s);
        end
        if (valid) m_had = 1'b1;
        if (hit && op == 2'b01 && m_impl(int'(ra)) && ra != 5'd1) m_reg[ra] = wd;
    endtask

    localparam bit [1:0] RD = 2'b10;
    localparam bit [1:0] WR = 2'b01;

    initial begin
        bit s;
        drv   = 1'b1;
        cfg   = 5'h0B;
        rst_n = 1'b0;
        m_had = 1'b0;
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        repeat (3) step(1'b1, 1'b0, 1'b0, 1'b0, "R1", s);
        rst_n = 1'b1;
        repeat (2) step(1'b1, 1'b0, 1'b0, 1'b0, "R1", s);

        frame(32, RD, 5'h0B, 5'd0,  16'h0, "R1");
        frame(32, RD, 5'h0B, 5'd16, 16'h0, "R1");
        frame(32, RD, 5'h0B, 5'd1,  16'h0, "R7");
        frame(32, WR, 5'h0B, 5'd16, 16'hA5C3, "R6");
        frame(32, RD, 5'h0B, 5'd16, 16'h0, "R6");
        frame(32, WR, 5'h0B, 5'd19, 16'hFFFF, "R7");
        frame(32, RD, 5'h0B, 5'd19, 16'h0, "R7");
        frame(32, WR, 5'h0B, 5'd0,  16'h1234, "R7");
        frame(32, RD, 5'h0B, 5'd0,  16'h0, "R7");
        frame(32, WR, 5'h0B, 5'd1,  16'hFFFF, "R7");
        frame(32, RD, 5'h0B, 5'd1,  16'h0, "R7");
        frame(32, WR, 5'h0B, 5'd5,  16'hBEEF, "R8");
        frame(32, RD, 5'h0B, 5'd5,  16'h0, "R8");
        frame(32, WR, 5'h0B, 5'd31, 16'h1357, "R8");
        frame(32, RD, 5'h0B, 5'd31, 16'h0, "R8");
        frame(32, RD, 5'h0B, 5'd20, 16'h0, "R8");

        frame(32, WR, 5'h0A, 5'd16, 16'h0000, "R4");
        frame(32, RD, 5'h0A, 5'd16, 16'h0, "R4");
        frame(32, RD, 5'h0B, 5'd16, 16'h0, "R4");
        cfg = 5'h1F;
        frame(32, WR, 5'h1F, 5'd17, 16'h7E81, "R4");
        frame(32, RD, 5'h1F, 5'd17, 16'h0, "R4");
        frame(32, RD, 5'h0B, 5'd17, 16'h0, "R4");
        cfg = 5'h0B;

        frame(31, WR, 5'h0B, 5'd17, 16'h1111, "R2");
        frame(32, RD, 5'h0B, 5'd17, 16'h0, "R2");
        frame(32, 2'b11, 5'h0B, 5'd17, 16'h2222, "R3");
        frame(32, RD, 5'h0B, 5'd17, 16'h0, "R3");
        frame(32, 2'b00, 5'h0B, 5'd17, 16'h3333, "R3");
        frame(32, RD, 5'h0B, 5'd17, 16'h0, "R3");

        frame(32, WR, 5'h0B, 5'd0,  16'h0040, "R9");
        frame(1,  WR, 5'h0B, 5'd18, 16'h5A5A, "R9");
        frame(1,  RD, 5'h0B, 5'd18, 16'h0, "R9");
        frame(1,  WR, 5'h0B, 5'd0,  16'h0000, "R9");
        frame(1,  WR, 5'h0B, 5'd18, 16'h0F0F, "R9");
        frame(32, RD, 5'h0B, 5'd18, 16'h0, "R9");
        frame(32, RD, 5'h0B, 5'd0,  16'h0, "R10");

        repeat (4) step(1'b1, 1'b0, 1'b0, 1'b0, "R5", s);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule